// File: doc/BRIEF.md
# Self-Timed Page Write Engine

This block sits behind the serial front end of a small non-volatile memory. A write session opens when the front end reports that a write opcode and its 10-bit start address are complete. The write-enable latch must be set, the chip must be selected and no write cycle may be in progress. Each data byte that the front end reports afterwards goes into a 32-byte page buffer. Successive bytes land at successive offsets inside the page. The offset wraps within the page, and a later byte overwrites an earlier one at the same offset.

When chip select is released, the block checks three things before it commits the page. At least one whole byte must have arrived. No bits of a following byte may have been shifted in. The page must lie outside the protected block. If all three hold, the block starts a self-timed write cycle of a programmable number of clock cycles. During that cycle it reports busy and streams the received bytes to the array, one per clock in ascending offset order. It also asks the front end to clear the write-enable latch. While busy, it refuses every command except status read.

Top module: `pw_engine`

## Requirements
- R1: A chip-select release in an open session with at least one byte received, no partial byte (`mid_byte_i` low) and an unprotected page raises `busy_o` on the next clock edge. In that same cycle `wel_clr_o` pulses high for exactly one cycle.
- R2: A chip-select release while `mid_byte_i` is high, or with no byte received, cancels the session: no busy period, no array write, no `wel_clr_o` pulse.
- R3: Byte k of a session (k from 0) is stored at page offset (start_addr[4:0] + k) mod 32. Every array write carries address bits [9:5] equal to start_addr[9:5].
- R4: When more than 32 bytes are sent, each offset holds the last byte written to it, and that byte is the only value written there.
- R5: During a busy period the array sees exactly one `arr_we_o` pulse for each offset that received data, none for the other offsets, in ascending offset order.
- R6: While `busy_o` is high, `cmd_accept_o` is low unless `cmd_rdsr_i` is high. A write opcode, data bytes and a chip-select release presented while busy start no new write.
- R7: A write opcode presented while `wel_i` is low opens no session. A later chip-select release gives no busy, no write and no `wel_clr_o`.
- R8: `bp_i` selects the protected range: 00 none, 01 addresses 0x300–0x3FF, 10 addresses 0x200–0x3FF, 11 all. A commit to a protected page gives no busy, no write and no `wel_clr_o`.
- R9: After reset, `busy_o`, `arr_we_o` and `wel_clr_o` are low and `cmd_accept_o` is high.
- R10: A busy period lasts exactly `WRITE_CYCLES` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| wr_cmd_i | input | 1 | Strobe: write opcode and address received |
| start_addr_i | input | 10 | Start address of the write |
| wel_i | input | 1 | Write-enable latch state |
| bp_i | input | 2 | Block protection code |
| byte_valid_i | input | 1 | Strobe: one data byte complete |
| byte_data_i | input | 8 | Received data byte |
| mid_byte_i | input | 1 | Bits of an unfinished byte have been shifted in |
| cmd_rdsr_i | input | 1 | Pending opcode is status read |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 10 | Array write address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Write cycle in progress |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |
| cmd_accept_o | output | 1 | The front end may accept the pending opcode |

## Verification
Several properties are checked on every cycle:
- a busy period begins only on a chip-select release, together with the write-enable clear pulse;
- array strobes occur only while busy, with a fixed page address and strictly ascending offsets;
- every busy period lasts the programmed length.

Some behaviour only the bench scenarios can show. That covers which offsets are written and with which values, including wrap and overwrite. It also covers cancellation by a partial byte or an empty page, and the refusal to act on a disabled latch or a protected page.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } sess_e;

  // Protection code vs. top two address bits (quarter index).
  function automatic logic quad_protected(input logic [1:0] code, input logic [1:0] quad);
    case (code)
      2'b01:   return quad == 2'b11;
      2'b10:   return quad[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [7:0]        wdata_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o
);
  localparam int Slots = 1 << PAGE_W;

  logic [7:0]       data_q  [Slots];
  logic [Slots-1:0] valid_q;

  for (genvar s = 0; s < Slots; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[s]  <= '0;
        valid_q[s] <= 1'b0;
      end else if (clr_i) begin
        valid_q[s] <= 1'b0;
      end else if (we_i && widx_i == PAGE_W'(s)) begin
        data_q[s]  <= wdata_i;
        valid_q[s] <= 1'b1;
      end
    end
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = valid_q[ridx_i];
endmodule

// File: rtl/pw_prot.sv
module pw_prot (
  input  logic [1:0] bp_i,
  input  logic [1:0] quad_i,
  output logic       prot_o
);
  import pw_pkg::*;
  assign prot_o = quad_protected(bp_i, quad_i);
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              scan_act_o,
  output logic [PAGE_W-1:0] scan_idx_o
);
  localparam int CntW = $clog2(WRITE_CYCLES + 1);
  localparam logic [PAGE_W-1:0] LastIdx = {PAGE_W{1'b1}};

  logic [CntW-1:0]   cnt_q;
  logic [PAGE_W-1:0] idx_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CntW'(WRITE_CYCLES);
      idx_q <= '0;
      act_q <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (act_q) begin
        if (idx_q == LastIdx) act_q <= 1'b0;
        else                  idx_q <= idx_q + 1'b1;
      end
    end
  end

  // Scan of 2**PAGE_W slots fits inside the busy window when WRITE_CYCLES >= 2**PAGE_W.
  assign busy_o     = cnt_q != '0;
  assign scan_act_o = act_q;
  assign scan_idx_o = idx_q;
endmodule

// File: rtl/pw_engine.sv
module pw_engine #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wr_cmd_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              wel_i,
  input  logic [1:0]        bp_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              mid_byte_i,
  input  logic              cmd_rdsr_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_data_o,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic              cmd_accept_o
);
  import pw_pkg::*;

  localparam int HiW = ADDR_W - PAGE_W;

  sess_e             state_q;
  logic [HiW-1:0]    page_q;
  logic [PAGE_W-1:0] ptr_q;
  logic              got_q;
  logic              clr_q;

  logic              sess_open, byte_take, cs_end, commit, prot;
  logic              scan_act, rvalid;
  logic [PAGE_W-1:0] scan_idx;
  logic [7:0]        rdata;

  assign sess_open = state_q == ST_IDLE && wr_cmd_i && !cs_n_i && wel_i && !busy_o;
  assign byte_take = state_q == ST_COLLECT && !cs_n_i && byte_valid_i;
  assign cs_end    = state_q == ST_COLLECT && cs_n_i;
  assign commit    = cs_end && got_q && !mid_byte_i && !prot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      got_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= commit;
      if (sess_open) begin
        state_q <= ST_COLLECT;
        page_q  <= start_addr_i[ADDR_W-1:PAGE_W];
        ptr_q   <= start_addr_i[PAGE_W-1:0];
        got_q   <= 1'b0;
      end else if (cs_end) begin
        state_q <= ST_IDLE;
      end else if (byte_take) begin
        ptr_q <= ptr_q + 1'b1;
        got_q <= 1'b1;
      end
    end
  end

  pw_page_buf #(.PAGE_W(PAGE_W)) i_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sess_open),
    .we_i     (byte_take),
    .widx_i   (ptr_q),
    .wdata_i  (byte_data_i),
    .ridx_i   (scan_idx),
    .rdata_o  (rdata),
    .rvalid_o (rvalid)
  );

  pw_prot i_prot (
    .bp_i   (bp_i),
    .quad_i (page_q[HiW-1:HiW-2]),
    .prot_o (prot)
  );

  pw_timer #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (commit),
    .busy_o     (busy_o),
    .scan_act_o (scan_act),
    .scan_idx_o (scan_idx)
  );

  assign arr_we_o     = scan_act && rvalid;
  assign arr_addr_o   = {page_q, scan_idx};
  assign arr_data_o   = rdata;
  assign wel_clr_o    = clr_q;
  assign cmd_accept_o = !busy_o || cmd_rdsr_i;
endmodule

// File: rtl/pw_engine_chk.sv
module pw_engine_chk #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 625000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic              cmd_rdsr_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              busy_o,
  input logic              wel_clr_o,
  input logic              cmd_accept_o
);
  logic [31:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (busy_o) len_q <= len_q + 1;
    else             len_q <= '0;
  end

  a_r1_start_on_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_n_i));
  a_r1_clr_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> wel_clr_o);
  a_r2_clr_only_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> $rose(busy_o));
  a_r5_we_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);
  a_r5_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o[PAGE_W-1:0] > $past(arr_addr_o[PAGE_W-1:0]));
  a_r3_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(arr_addr_o[ADDR_W-1:PAGE_W]));
  a_r6_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !cmd_rdsr_i |-> !cmd_accept_o);
  a_r10_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> len_q == 32'(WRITE_CYCLES));
endmodule

bind pw_engine pw_engine_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) i_pw_engine_chk (.*);

// File: tb/test_pw_engine.sv
module test_pw_engine;
  localparam int CYC = 64;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cs_n_i = 1'b1, wr_cmd_i = 1'b0, wel_i = 1'b0;
  logic [9:0] start_addr_i = '0;
  logic [1:0] bp_i = '0;
  logic       byte_valid_i = 1'b0, mid_byte_i = 1'b0, cmd_rdsr_i = 1'b0;
  logic [7:0] byte_data_i = '0;
  logic       arr_we_o, busy_o, wel_clr_o, cmd_accept_o;
  logic [9:0] arr_addr_o;
  logic [7:0] arr_data_o;

  int vecs = 0, bad = 0;

  always #4ns clk_i = ~clk_i;

  pw_engine #(.ADDR_W(10), .PAGE_W(5), .WRITE_CYCLES(CYC)) i_pw_engine (.*);

  typedef struct packed {
    logic [9:0] addr;
    logic [6:0] n;
    logic [7:0] seed;
    logic       mid;
    logic       wel;
    logic [1:0] bp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VT [12] = '{
    '{10'h045, 7'd1,  8'h11, 1'b0, 1'b1, 2'b00, 4'd1},  // R1 single byte
    '{10'h05E, 7'd4,  8'h20, 1'b0, 1'b1, 2'b00, 4'd3},  // R3 offset wrap
    '{10'h100, 7'd35, 8'h40, 1'b0, 1'b1, 2'b00, 4'd4},  // R4 overwrite
    '{10'h010, 7'd3,  8'h70, 1'b1, 1'b1, 2'b00, 4'd2},  // R2 partial byte
    '{10'h010, 7'd0,  8'h00, 1'b0, 1'b1, 2'b00, 4'd2},  // R2 no byte
    '{10'h0A0, 7'd2,  8'h90, 1'b0, 1'b0, 2'b00, 4'd7},  // R7 latch clear
    '{10'h300, 7'd2,  8'hA0, 1'b0, 1'b1, 2'b01, 4'd8},  // R8 quarter protected
    '{10'h2F0, 7'd2,  8'hB0, 1'b0, 1'b1, 2'b01, 4'd8},  // R8 below quarter
    '{10'h200, 7'd2,  8'hC0, 1'b0, 1'b1, 2'b10, 4'd8},  // R8 half protected
    '{10'h1F0, 7'd2,  8'hD0, 1'b0, 1'b1, 2'b10, 4'd8},  // R8 below half
    '{10'h000, 7'd2,  8'hE0, 1'b0, 1'b1, 2'b11, 4'd8},  // R8 all protected
    '{10'h3E7, 7'd32, 8'h01, 1'b0, 1'b1, 2'b00, 4'd5}   // R5 full page
  };

  int busy_n, clr_n, page_bad, accept_bad;
  int act_cnt [32];
  logic [7:0] act_val [32];

  task automatic chk(input bit ok, input int req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_and_send(input logic [9:0] a, input int n, input logic [7:0] seed,
                               input logic wel, input logic [1:0] bp);
    @(negedge clk_i);
    start_addr_i = a; wel_i = wel; bp_i = bp; cs_n_i = 1'b0; wr_cmd_i = 1'b1;
    @(negedge clk_i);
    wr_cmd_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_valid_i = 1'b1; byte_data_i = 8'(seed + k);
      @(negedge clk_i);
      byte_valid_i = 1'b0;
    end
  endtask

  task automatic observe(input logic [4:0] page);
    busy_n = 0; clr_n = 0; page_bad = 0; accept_bad = 0;
    for (int o = 0; o < 32; o++) begin act_cnt[o] = 0; act_val[o] = '0; end
    for (int i = 0; i < CYC + 8; i++) begin
      @(negedge clk_i);
      mid_byte_i = 1'b0;
      if (busy_o) begin
        busy_n++;
        if (cmd_accept_o) accept_bad++;
      end
      if (wel_clr_o) clr_n++;
      if (arr_we_o) begin
        act_cnt[arr_addr_o[4:0]]++;
        act_val[arr_addr_o[4:0]] = arr_data_o;
        if (arr_addr_o[9:5] != page) page_bad++;
      end
    end
  endtask

  initial begin
    #(8ns * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!busy_o && !arr_we_o && !wel_clr_o, 9, {busy_o, arr_we_o, wel_clr_o}, 0);
    chk(cmd_accept_o, 9, cmd_accept_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && cmd_accept_o, 9, {busy_o, cmd_accept_o}, 1);

    foreach (VT[v]) begin
      automatic vec_t t = VT[v];
      automatic bit prot = (t.bp == 2'b01 && t.addr[9:8] == 2'b11) ||
                           (t.bp == 2'b10 && t.addr[9]) || (t.bp == 2'b11);
      automatic bit exp_c = (t.n != 0) && !t.mid && t.wel && !prot;
      automatic int  ecnt [32];
      automatic logic [7:0] eval [32];
      automatic int  wbad = 0;
      for (int o = 0; o < 32; o++) begin ecnt[o] = 0; eval[o] = '0; end
      if (exp_c)
        for (int k = 0; k < int'(t.n); k++) begin
          ecnt[(int'(t.addr[4:0]) + k) % 32] = 1;
          eval[(int'(t.addr[4:0]) + k) % 32] = 8'(t.seed + k);
        end
      open_and_send(t.addr, int'(t.n), t.seed, t.wel, t.bp);
      mid_byte_i = t.mid; cs_n_i = 1'b1;
      observe(t.addr[9:5]);
      chk((busy_n != 0) == exp_c, int'(t.req), busy_n != 0, exp_c);
      if (exp_c) chk(busy_n == CYC, 10, busy_n, CYC);  // R10
      chk(clr_n == int'(exp_c), int'(t.req), clr_n, exp_c);
      for (int o = 0; o < 32; o++)
        if (act_cnt[o] != ecnt[o] || (ecnt[o] != 0 && act_val[o] != eval[o])) wbad++;
      chk(wbad == 0 && page_bad == 0, int'(t.req), wbad + page_bad, 0);
      chk(accept_bad == 0, 6, accept_bad, 0);
    end

    // R6: status read accepted while busy, new write ignored while busy
    open_and_send(10'h080, 2, 8'h55, 1'b1, 2'b00);
    cs_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    cmd_rdsr_i = 1'b1;
    #1ns;
    chk(busy_o && cmd_accept_o, 6, {busy_o, cmd_accept_o}, 3);
    cmd_rdsr_i = 1'b0;
    open_and_send(10'h0C0, 2, 8'h66, 1'b1, 2'b00);
    cs_n_i = 1'b1;
    repeat (CYC) @(negedge clk_i);
    observe(5'h06);
    chk(busy_n == 0 && clr_n == 0, 6, busy_n + clr_n, 0);
    chk(act_cnt[0] == 0 && act_cnt[1] == 0, 6, act_cnt[0] + act_cnt[1], 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule